// File: doc/BRIEF.md
# Linkable Counter/Timer Pair

This block holds two 16-bit down-counters that share one byte-wide register port. Each channel has a reload value, a mode byte and a command/status byte. The reload value and the live count are each reached as a high byte and a low byte. A channel starts when software writes a trigger bit, or on a rising edge of its external trigger pin when that pin is enabled. The trigger loads the reload value into the count. The channel then counts down on every clock, or on rising edges of its external count pin when that pin is enabled. Counting proceeds only while the software gate bit is set and, when enabled, the external gate pin is high.

At terminal count a channel either reloads and keeps running (continuous) or stops (single-cycle). It shapes its waveform as a one-count pulse, a one-shot level or a square wave. An output-enable bit passes that waveform to the output pin. A freeze bit captures the count so that software can read both bytes coherently, and the capture is released by reading the low byte. A link field lets the waveform of channel 0 act on channel 1 in one of three ways: as its gate, as its trigger, or as its count clock.

Top module: `ltmr_pair`

## Requirements
- R1: After reset every register reads 0x00, `rdata` is 0x00 and both `tmr_out` bits are low.
- R2: The address is {link, channel, offset}. The offsets are: mode at 0, command/status at 1, count high byte at 2, count low byte at 3, reload high byte at 4 and reload low byte at 5. Address 0x10 holds the link field in bits [1:0]. A read returns data on `rdata` one clock after `rd_en`. Command bit 1 is a trigger that loads the reload value and reads back as 0. Status bit 0 reads 1 while a count is in progress, and status bit 2 reads back the gate bit.
- R3: With mode[1:0]=1 (one-shot), the waveform rises at the trigger and falls on the Nth count event, where N is the reload value.
- R4: With mode bit 7 clear (single-cycle), status bit 0 clears at terminal count and the channel then stays idle.
- R5: With mode[1:0]=2 (square wave) and mode bit 7 set, the waveform toggles every N count events.
- R6: With mode[1:0]=0 (pulse), the waveform is high for exactly one count event at each terminal count. Code 3 acts as pulse.
- R7: The count holds while command bit 2 (gate) is clear. It also holds while mode bit 3 is set and `ext_gate` is low.
- R8: A trigger that arrives while a count is in progress is ignored unless mode bit 2 (retrigger) is set. With that bit set, the trigger reloads the count.
- R9: When mode bit 5 is set, count events are rising edges of `ext_cnt`. When mode bit 4 is set, a rising edge of `ext_trig` acts as a trigger.
- R10: `tmr_out` shows the waveform only while mode bit 6 is set, and is low otherwise.
- R11: Writing command bit 3 captures the count. Both count bytes then return the captured value until the count low byte is read, which returns the captured byte and releases the capture. Status bit 3 reads 1 while the capture is held.
- R12: The link field sets how channel 0's waveform drives channel 1. Value 1 makes it a gate. Value 2 makes its rising edge a trigger. Value 3 makes its rising edge a count event. Value 0 leaves the channels independent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| ext_cnt | input | 2 | External count input per channel |
| ext_gate | input | 2 | External gate input per channel |
| ext_trig | input | 2 | External trigger input per channel |
| tmr_out | output | 2 | Waveform output per channel |

## Verification
An off-by-one in the terminal-count compare would move the waveform edge one clock early or late. The bench would see this on the very cycle the edge was predicted, because every waveform check is timed to a counted clock edge from the trigger. A busy flag that is stuck or cleared early would show in the status byte, and it would also let a trigger through that should have been ignored, which changes the count bytes read next. A capture register that fails to hold or release would show when the low byte is read, and link decoding errors would shift the edge of channel 1's output by several clocks.

// File: rtl/ltmr_pkg.sv
package ltmr_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int NCH    = 2;
  localparam int OFF_W  = 3;
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int ADDR_W = OFF_W + CH_W + 1;

  typedef enum logic [1:0] {
    SHP_PULSE   = 2'd0,
    SHP_ONESHOT = 2'd1,
    SHP_SQUARE  = 2'd2,
    SHP_RSVD    = 2'd3
  } shape_e;

  typedef enum logic [1:0] {
    LNK_NONE = 2'd0,
    LNK_GATE = 2'd1,
    LNK_TRIG = 2'd2,
    LNK_CLK  = 2'd3
  } link_e;

  localparam int MB_CONT   = 7;
  localparam int MB_OUTEN  = 6;
  localparam int MB_XCNT   = 5;
  localparam int MB_XTRIG  = 4;
  localparam int MB_XGATE  = 3;
  localparam int MB_RETRIG = 2;

  localparam int CB_FREEZE = 3;
  localparam int CB_GATE   = 2;
  localparam int CB_TRIG   = 1;
  localparam int CB_BUSY   = 0;

  localparam logic [OFF_W-1:0] OFF_MODE   = 3'd0;
  localparam logic [OFF_W-1:0] OFF_CMD    = 3'd1;
  localparam logic [OFF_W-1:0] OFF_CNT_HI = 3'd2;
  localparam logic [OFF_W-1:0] OFF_CNT_LO = 3'd3;
  localparam logic [OFF_W-1:0] OFF_TC_HI  = 3'd4;
  localparam logic [OFF_W-1:0] OFF_TC_LO  = 3'd5;
endpackage

// File: rtl/ltmr_core.sv
module ltmr_core
  import ltmr_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [BYTE_W-1:0]   mode,
  input  logic [W-1:0]        tc,
  input  logic                sw_gate,
  input  logic                sw_trig,
  input  logic                ext_cnt,
  input  logic                ext_gate,
  input  logic                ext_trig,
  input  link_e               link_sel,
  input  logic                link_in,
  output logic [W-1:0]        cnt_o,
  output logic                busy_o,
  output logic                wave_o
);
  shape_e      shape;
  logic        pulse_like;
  logic [W-1:0] cnt_q;
  logic        busy_q, wave_q;
  logic        cnt_d, trig_d, link_d;
  logic        cnt_rise, trig_rise, link_rise;
  logic        count_src, gate_ok, trig, load, tick, step, at_end;

  assign shape      = shape_e'(mode[1:0]);
  assign pulse_like = (shape == SHP_PULSE) || (shape == SHP_RSVD);

  // edge history of the asynchronous-free external pins and link input
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_d  <= 1'b0;
      trig_d <= 1'b0;
      link_d <= 1'b0;
    end else begin
      cnt_d  <= ext_cnt;
      trig_d <= ext_trig;
      link_d <= link_in;
    end
  end

  assign cnt_rise  = ext_cnt  & ~cnt_d;
  assign trig_rise = ext_trig & ~trig_d;
  assign link_rise = link_in  & ~link_d;

  always_comb begin
    if (link_sel == LNK_CLK)      count_src = link_rise;
    else if (mode[MB_XCNT])       count_src = cnt_rise;
    else                          count_src = 1'b1;
  end

  assign gate_ok = sw_gate
                 & (~mode[MB_XGATE] | ext_gate)
                 & ((link_sel == LNK_GATE) ? link_in : 1'b1);
  assign trig    = sw_trig
                 | (mode[MB_XTRIG] & trig_rise)
                 | ((link_sel == LNK_TRIG) & link_rise);
  assign load    = trig & (~busy_q | mode[MB_RETRIG]);
  assign tick    = gate_ok & count_src;
  assign step    = busy_q & tick;
  assign at_end  = step & (cnt_q <= W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      wave_q <= 1'b0;
    end else if (load) begin
      cnt_q  <= tc;
      busy_q <= 1'b1;
      case (shape)
        SHP_ONESHOT: wave_q <= 1'b1;
        SHP_SQUARE:  wave_q <= wave_q;
        default:     wave_q <= 1'b0;
      endcase
    end else if (at_end) begin
      busy_q <= mode[MB_CONT];
      cnt_q  <= mode[MB_CONT] ? tc : '0;
      case (shape)
        SHP_ONESHOT: wave_q <= 1'b0;
        SHP_SQUARE:  wave_q <= ~wave_q;
        default:     wave_q <= 1'b1;
      endcase
    end else if (step) begin
      cnt_q <= cnt_q - W'(1);
      if (pulse_like) wave_q <= 1'b0;
    end else if (pulse_like && tick && wave_q) begin
      wave_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign busy_o = busy_q;
  assign wave_o = wave_q;

  // R7: a closed gate freezes the count unless a load happens
  assert_gate_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!gate_ok && !load) |=> $stable(cnt_q));

  // R8: without retrigger a running count only moves by counting
  assert_retrig_ignore_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !mode[MB_RETRIG] && !step) |=> $stable(cnt_q));

  // R4: the busy flag only drops in single-cycle operation
  assert_single_stop_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> !$past(mode[MB_CONT]));

  // R3: a one-shot level ends only on the last count
  assert_oneshot_end_R3: assert property (@(posedge clk) disable iff (rst)
    ($fell(wave_q) && $past(shape == SHP_ONESHOT)) |-> ($past(cnt_q) <= W'(1)));
endmodule

// File: rtl/ltmr_regs.sv
module ltmr_regs
  import ltmr_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              sel,
  input  logic [OFF_W-1:0]  off,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [W-1:0]      cnt_i,
  input  logic              busy_i,
  output logic [BYTE_W-1:0] mode_o,
  output logic [W-1:0]      tc_o,
  output logic              gate_o,
  output logic              trig_o,
  output logic [BYTE_W-1:0] rd_o
);
  localparam int HI = W - 1;

  logic [BYTE_W-1:0] mode_q;
  logic [W-1:0]      tc_q, held_q, view;
  logic              gate_q, frz_q;
  logic              we, re, lo_read;

  assign we      = wr_en & sel;
  assign re      = rd_en & sel;
  assign lo_read = re && (off == OFF_CNT_LO);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      tc_q   <= '0;
      gate_q <= 1'b0;
      frz_q  <= 1'b0;
      held_q <= '0;
    end else begin
      if (we) begin
        case (off)
          OFF_MODE:  mode_q <= wdata;
          OFF_CMD: begin
            gate_q <= wdata[CB_GATE];
            if (wdata[CB_FREEZE] && !frz_q) begin
              frz_q  <= 1'b1;
              held_q <= cnt_i;
            end
          end
          OFF_TC_HI: tc_q[HI -: BYTE_W] <= wdata;
          OFF_TC_LO: tc_q[BYTE_W-1:0]   <= wdata;
          default: ;
        endcase
      end
      if (lo_read && frz_q) frz_q <= 1'b0;
    end
  end

  assign view   = frz_q ? held_q : cnt_i;
  assign mode_o = mode_q;
  assign tc_o   = tc_q;
  assign gate_o = gate_q;
  assign trig_o = we && (off == OFF_CMD) && wdata[CB_TRIG];

  always_comb begin
    case (off)
      OFF_MODE:   rd_o = mode_q;
      OFF_CMD:    rd_o = {4'b0000, frz_q, gate_q, 1'b0, busy_i};
      OFF_CNT_HI: rd_o = view[HI -: BYTE_W];
      OFF_CNT_LO: rd_o = view[BYTE_W-1:0];
      OFF_TC_HI:  rd_o = tc_q[HI -: BYTE_W];
      OFF_TC_LO:  rd_o = tc_q[BYTE_W-1:0];
      default:    rd_o = '0;
    endcase
  end

  // R11: a held capture stays put until the low byte is read
  assert_freeze_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (frz_q && !lo_read) |=> (frz_q && $stable(held_q)));
endmodule

// File: rtl/ltmr_pair.sv
module ltmr_pair
  import ltmr_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int AW = ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic [NCH-1:0]    ext_cnt,
  input  logic [NCH-1:0]    ext_gate,
  input  logic [NCH-1:0]    ext_trig,
  output logic [NCH-1:0]    tmr_out
);
  localparam int LBIT = AW - 1;

  link_e              link_q;
  logic [NCH-1:0]     wave;
  logic [BYTE_W-1:0]  rd_arr [NCH];
  logic [CH_W-1:0]    ch_idx;
  logic               link_hit;

  assign ch_idx   = addr[OFF_W +: CH_W];
  assign link_hit = addr[LBIT] && (addr[LBIT-1:0] == '0);

  always_ff @(posedge clk) begin
    if (rst) link_q <= LNK_NONE;
    else if (wr_en && link_hit) link_q <= link_e'(wdata[1:0]);
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [BYTE_W-1:0] mode;
    logic [CW-1:0]     tc, cnt;
    logic              gate, trig, busy, sel;
    link_e             lsel;
    logic              lin;

    assign sel = !addr[LBIT] && (ch_idx == CH_W'(g));

    if (g == 0) begin : g_head
      assign lsel = LNK_NONE;
      assign lin  = 1'b0;
    end else begin : g_linked
      assign lsel = link_q;
      assign lin  = wave[g-1];
    end

    ltmr_regs #(.W(CW)) u_regs (
      .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .sel(sel),
      .off(addr[OFF_W-1:0]), .wdata(wdata), .cnt_i(cnt), .busy_i(busy),
      .mode_o(mode), .tc_o(tc), .gate_o(gate), .trig_o(trig), .rd_o(rd_arr[g])
    );

    ltmr_core #(.W(CW)) u_core (
      .clk(clk), .rst(rst), .mode(mode), .tc(tc), .sw_gate(gate), .sw_trig(trig),
      .ext_cnt(ext_cnt[g]), .ext_gate(ext_gate[g]), .ext_trig(ext_trig[g]),
      .link_sel(lsel), .link_in(lin), .cnt_o(cnt), .busy_o(busy), .wave_o(wave[g])
    );

    assign tmr_out[g] = wave[g] & mode[MB_OUTEN];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) rdata <= addr[LBIT] ? {6'b0, link_q} : rd_arr[ch_idx];
  end
endmodule

// File: tb/ltmr_pair_bench.sv
module ltmr_pair_bench;
  localparam int CLK_P = 10;
  localparam int WD    = 100000;

  logic       clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [1:0] ext_cnt = '0, ext_gate = '0, ext_trig = '0, tmr_out;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  ltmr_pair u_ltmr_pair (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ext_cnt(ext_cnt), .ext_gate(ext_gate),
    .ext_trig(ext_trig), .tmr_out(tmr_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ext_cnt = '0; ext_gate = '0; ext_trig = '0;
    idle(3);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    do_reset();
    chk(rdata == 8'h00, "R1 rdata", rdata, 0);
    chk(tmr_out == 2'b00, "R1 tmr_out", tmr_out, 0);
    rd(5'h00, v); chk(v == 8'h00, "R1 mode", v, 0);
    rd(5'h01, v); chk(v == 8'h00, "R1 status", v, 0);
    rd(5'h10, v); chk(v == 8'h00, "R1 link", v, 0);
  endtask

  task automatic t_load_gate_retrig();
    logic [7:0] v;
    do_reset();
    wr(5'h05, 8'h34); wr(5'h04, 8'h12); wr(5'h01, 8'h02);
    rd(5'h02, v); chk(v == 8'h12, "R2 count hi", v, 8'h12);
    rd(5'h03, v); chk(v == 8'h34, "R2 count lo", v, 8'h34);
    rd(5'h01, v); chk(v == 8'h01, "R2 busy status", v, 8'h01);
    idle(5);
    rd(5'h03, v); chk(v == 8'h34, "R7 sw gate closed", v, 8'h34);
    wr(5'h00, 8'h08); wr(5'h01, 8'h04);
    idle(6);
    rd(5'h03, v); chk(v == 8'h34, "R7 ext gate low", v, 8'h34);
    ext_gate[0] = 1'b1;
    idle(4);
    rd(5'h03, v); chk(v != 8'h34, "R7 gate open counts", v, 8'h34);
    wr(5'h01, 8'h00);
    ext_gate[0] = 1'b0;
    wr(5'h05, 8'h50); wr(5'h04, 8'h00); wr(5'h00, 8'h00);
    wr(5'h01, 8'h02);
    rd(5'h02, v); chk(v == 8'h12, "R8 trigger ignored", v, 8'h12);
    wr(5'h00, 8'h04); wr(5'h01, 8'h02);
    rd(5'h02, v); chk(v == 8'h00, "R8 retrigger hi", v, 0);
    rd(5'h03, v); chk(v == 8'h50, "R8 retrigger lo", v, 8'h50);
  endtask

  task automatic t_oneshot_single();
    logic [7:0] v;
    do_reset();
    wr(5'h05, 8'h05); wr(5'h00, 8'h41); wr(5'h01, 8'h06);
    chk(tmr_out[0] == 1'b1, "R3 rise at trigger", tmr_out[0], 1);
    idle(4); chk(tmr_out[0] == 1'b1, "R3 high before end", tmr_out[0], 1);
    idle(1); chk(tmr_out[0] == 1'b0, "R3 fall at end", tmr_out[0], 0);
    rd(5'h01, v); chk(v == 8'h04, "R4 busy cleared", v, 8'h04);
    idle(20); chk(tmr_out[0] == 1'b0, "R4 stays idle", tmr_out[0], 0);
  endtask

  task automatic t_square();
    do_reset();
    wr(5'h05, 8'h03); wr(5'h00, 8'hC2); wr(5'h01, 8'h06);
    idle(2); chk(tmr_out[0] == 1'b0, "R5 before first toggle", tmr_out[0], 0);
    idle(1); chk(tmr_out[0] == 1'b1, "R5 first toggle", tmr_out[0], 1);
    idle(2); chk(tmr_out[0] == 1'b1, "R5 hold", tmr_out[0], 1);
    idle(1); chk(tmr_out[0] == 1'b0, "R5 second toggle", tmr_out[0], 0);
  endtask

  task automatic t_pulse();
    logic [7:0] v;
    do_reset();
    wr(5'h05, 8'h04); wr(5'h00, 8'hC0); wr(5'h01, 8'h06);
    idle(3); chk(tmr_out[0] == 1'b0, "R6 low before end", tmr_out[0], 0);
    idle(1); chk(tmr_out[0] == 1'b1, "R6 pulse high", tmr_out[0], 1);
    idle(1); chk(tmr_out[0] == 1'b0, "R6 one count wide", tmr_out[0], 0);
    idle(3); chk(tmr_out[0] == 1'b1, "R6 repeats", tmr_out[0], 1);
    rd(5'h01, v); chk(v == 8'h05, "R6 continuous stays busy", v, 8'h05);
  endtask

  task automatic t_external();
    do_reset();
    wr(5'h05, 8'h03); wr(5'h00, 8'h61); wr(5'h01, 8'h06);
    idle(10); chk(tmr_out[0] == 1'b1, "R9 no clock counting", tmr_out[0], 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); ext_cnt[0] = 1'b1;
      @(negedge clk); ext_cnt[0] = 1'b0;
      if (i == 1) chk(tmr_out[0] == 1'b1, "R9 two edges", tmr_out[0], 1);
    end
    chk(tmr_out[0] == 1'b0, "R9 third edge ends", tmr_out[0], 0);
    do_reset();
    wr(5'h05, 8'h02); wr(5'h00, 8'h51); wr(5'h01, 8'h04);
    chk(tmr_out[0] == 1'b0, "R9 not yet triggered", tmr_out[0], 0);
    @(negedge clk); ext_trig[0] = 1'b1;
    @(negedge clk);
    chk(tmr_out[0] == 1'b1, "R9 ext trigger", tmr_out[0], 1);
    ext_trig[0] = 1'b0;
  endtask

  task automatic t_outen();
    do_reset();
    wr(5'h05, 8'h05); wr(5'h00, 8'h01); wr(5'h01, 8'h06);
    chk(tmr_out[0] == 1'b0, "R10 masked", tmr_out[0], 0);
    wr(5'h00, 8'h41);
    chk(tmr_out[0] == 1'b1, "R10 enabled", tmr_out[0], 1);
  endtask

  task automatic t_freeze();
    logic [7:0] v;
    do_reset();
    wr(5'h04, 8'h03); wr(5'h05, 8'h00); wr(5'h00, 8'hC0);
    wr(5'h01, 8'h06); wr(5'h01, 8'h0C);
    idle(20);
    rd(5'h02, v); chk(v == 8'h02, "R11 held hi", v, 8'h02);
    rd(5'h01, v); chk(v == 8'h0D, "R11 status held", v, 8'h0D);
    rd(5'h03, v); chk(v == 8'hFF, "R11 held lo", v, 8'hFF);
    rd(5'h01, v); chk(v == 8'h05, "R11 released", v, 8'h05);
    rd(5'h03, v); chk(v != 8'hFF, "R11 live again", v, 8'hFF);
  endtask

  task automatic t_link();
    do_reset();
    wr(5'h10, 8'h03);
    wr(5'h0D, 8'h03); wr(5'h08, 8'h41); wr(5'h09, 8'h06);
    wr(5'h05, 8'h02); wr(5'h00, 8'h82);
    idle(10); chk(tmr_out[1] == 1'b1, "R12 clock link idle", tmr_out[1], 1);
    wr(5'h01, 8'h06);
    idle(10); chk(tmr_out[1] == 1'b1, "R12 clock link third edge pending", tmr_out[1], 1);
    idle(1);  chk(tmr_out[1] == 1'b0, "R12 clock link ends", tmr_out[1], 0);
    do_reset();
    wr(5'h10, 8'h02);
    wr(5'h0D, 8'h05); wr(5'h08, 8'h41); wr(5'h09, 8'h04);
    wr(5'h05, 8'h02); wr(5'h00, 8'h82); wr(5'h01, 8'h06);
    idle(2); chk(tmr_out[1] == 1'b0, "R12 trig link before edge", tmr_out[1], 0);
    idle(1); chk(tmr_out[1] == 1'b1, "R12 trig link fires", tmr_out[1], 1);
    idle(5); chk(tmr_out[1] == 1'b0, "R12 trig link count done", tmr_out[1], 0);
    do_reset();
    wr(5'h10, 8'h01);
    wr(5'h0D, 8'h03); wr(5'h08, 8'h41); wr(5'h09, 8'h06);
    idle(10); chk(tmr_out[1] == 1'b1, "R12 gate link closed", tmr_out[1], 1);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", WD, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_load_gate_retrig();
    t_oneshot_single();
    t_square();
    t_pulse();
    t_external();
    t_outen();
    t_freeze();
    t_link();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule